// File: doc/BRIEF.md
# Embedded transmit command interpreter

This block sits on the byte path between a transmit source and a serial transmitter. It lets the software that fills the transmit stream steer the line itself. With command parsing switched on, a zero byte works as an escape. The byte after it is read as a line command: start a break, end a break, insert a timed pause, or send one literal zero. Any other byte gives ordinary data, which passes through unchanged and in order.

Both sides of the block are valid/ready byte streams. The block also drives three outputs:
- a break level for the transmitter, which holds the line at space while set;
- a busy flag;
- a sticky error flag, raised when an escape is followed by a command byte that means nothing.

A pause takes one length byte after the pause command. Its unit is a prescaled tick of `TICK_DIV` clock cycles, and input is stalled until the pause has elapsed. Serialisation, baud timing and parity belong to the transmitter and are not part of this block.

Top module: `etx_cmd_interp`

## Requirements
- R1: After reset, out_valid, line_break, busy and cmd_err are all 0.
- R2: With cmd_en = 0, every accepted byte, 0x00 included, appears once on out_data, unchanged and in input order.
- R3: With cmd_en = 1, every accepted byte other than 0x00 that is not a command or pause length appears unchanged and in order. The escape byte (0x00), the command byte after it and the pause length byte never appear on the output.
- R4: With cmd_en = 1, the pair 0x00, 0x00 produces exactly one 0x00 output byte.
- R5: The pair 0x00, 0x81 sets line_break from the cycle after the command byte is accepted. While line_break is 1, no data byte is accepted (in_ready is 0 for it) and out_valid does not rise.
- R6: The pair 0x00, 0x83 clears line_break from the cycle after the command byte is accepted, and data flows again afterwards.
- R7: The sequence 0x00, 0x82, L holds in_ready at 0 for exactly L × TICK_DIV cycles, starting in the cycle after L is accepted. L = 0 gives no stall.
- R8: An escape followed by any command byte other than 0x00, 0x81, 0x82 or 0x83 is dropped without output, and cmd_err is set. cmd_err stays 1 until reset.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged on the next cycle.
- R10: busy is 1 from the cycle after an escape is accepted until the command sequence completes, and stays 1 for the whole of a pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_en | input | 1 | Enables interpretation of 0x00 as an escape |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte for the transmitter |
| out_ready | input | 1 | Transmitter takes the output byte |
| line_break | output | 1 | Hold the line at space while high |
| busy | output | 1 | Command sequence or pause in progress |
| cmd_err | output | 1 | Sticky flag: unknown command seen |

## Verification
The bench builds the block with TICK_DIV = 3. With a prescaler that is not a power of two, an off-by-one in the tick count shows up as a wrong stall length for every nonzero pause. Pause lengths up to 7 are short enough that many pauses fit among the randomised token streams. Those streams mix data, literal zeros, break pairs, pauses and unknown commands, and the output acceptance rate is randomised. Together this exercises command bytes waiting for the output slot to drain and data held back behind a break.

// File: rtl/etx_pkg.sv
package etx_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ESC_BYTE    = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_BRK_ON  = 8'h81;
    localparam logic [BYTE_W-1:0] CMD_PAUSE   = 8'h82;
    localparam logic [BYTE_W-1:0] CMD_BRK_OFF = 8'h83;

    typedef enum logic [1:0] {
        PS_DATA = 2'd0,
        PS_CMD  = 2'd1,
        PS_LEN  = 2'd2
    } parse_e;

    typedef struct packed {
        parse_e             st;
        logic               brk;
        logic               err;
        logic               ov;
        logic [BYTE_W-1:0]  od;
    } core_s;
endpackage

// File: rtl/etx_tick_div.sv
module etx_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = en && (pre_q == PW'(DIV - 1));
        pre_d = pre_q;
        if (clr)       pre_d = '0;
        else if (tick) pre_d = '0;
        else if (en)   pre_d = pre_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R7
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pre_q) || pre_q == '0);
endmodule

// File: rtl/etx_delay_count.sv
module etx_delay_count #(
    parameter int DIV = 4,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          running
);
    logic          tick;
    logic [CW-1:0] cnt_d, cnt_q;

    etx_tick_div #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .en    (running),
        .tick  (tick)
    );

    always_comb begin
        running = (cnt_q != '0);
        cnt_d   = cnt_q;
        if (load)      cnt_d = len;
        else if (tick) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(len));

    // R7
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load) |=> (cnt_q == $past(cnt_q)) || (cnt_q == CW'($past(cnt_q) - CW'(1))));
endmodule

// File: rtl/etx_cmd_interp.sv
module etx_cmd_interp
    import etx_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              line_break,
    output logic              busy,
    output logic              cmd_err
);
    core_s             q, d;
    logic              running;
    logic              load;
    logic              take;
    logic              acc;
    logic              slot_free;
    logic              is_esc;

    etx_delay_count #(.DIV(TICK_DIV), .CW(BYTE_W)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .len     (in_data),
        .running (running)
    );

    always_comb begin
        d         = q;
        take      = 1'b0;
        load      = 1'b0;
        in_ready  = 1'b0;
        slot_free = !q.ov || out_ready;
        is_esc    = (in_data == ESC_BYTE);

        // Acceptance: data needs a free slot and no break; commands need an empty slot.
        case (q.st)
            PS_DATA: begin
                if (!running) begin
                    if (cmd_en && is_esc) in_ready = 1'b1;
                    else                  in_ready = slot_free && !q.brk;
                end
            end
            PS_CMD:  in_ready = is_esc ? (slot_free && !q.brk) : !q.ov;
            PS_LEN:  in_ready = 1'b1;
            default: in_ready = 1'b0;
        endcase

        acc = in_valid && in_ready;

        if (q.ov && out_ready) d.ov = 1'b0;

        if (acc) begin
            case (q.st)
                PS_DATA: begin
                    if (cmd_en && is_esc) d.st = PS_CMD;
                    else                  take = 1'b1;
                end
                PS_CMD: begin
                    d.st = PS_DATA;
                    case (in_data)
                        ESC_BYTE:    take  = 1'b1;
                        CMD_BRK_ON:  d.brk = 1'b1;
                        CMD_BRK_OFF: d.brk = 1'b0;
                        CMD_PAUSE:   d.st  = PS_LEN;
                        default:     d.err = 1'b1;
                    endcase
                end
                PS_LEN: begin
                    d.st = PS_DATA;
                    load = 1'b1;
                end
                default: d.st = PS_DATA;
            endcase
        end

        if (take) begin
            d.ov = 1'b1;
            d.od = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= PS_DATA;
            q.brk <= 1'b0;
            q.err <= 1'b0;
            q.ov  <= 1'b0;
            q.od  <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid  = q.ov;
    assign out_data   = q.od;
    assign line_break = q.brk;
    assign cmd_err    = q.err;
    assign busy       = (q.st != PS_DATA) || running;

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    // R5
    brk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_break && !out_valid) |=> !out_valid);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    // R7
    pause_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !in_ready);

    // R3
    cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && q.st == PS_CMD && in_data != ESC_BYTE) |=> !out_valid);

    // R10
    busy_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && q.st == PS_DATA && cmd_en && in_data == ESC_BYTE) |=> busy);
endmodule

// File: tb/etx_cmd_interp_tb.sv
module etx_cmd_interp_tb;
    localparam int TICK_DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h41;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;
    logic       line_break;
    logic       busy;
    logic       cmd_err;

    int         n_chk = 0;
    int         n_fail = 0;
    int         rate = 100;
    bit         done = 1'b0;
    string      cur_req = "R2";
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    etx_cmd_interp #(.TICK_DIV(TICK_DIV)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_en     (cmd_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready),
        .line_break (line_break),
        .busy       (busy),
        .cmd_err    (cmd_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_known(input logic [7:0] c);
        return (c == 8'h00) || (c == 8'h81) || (c == 8'h82) || (c == 8'h83);
    endfunction

    function automatic logic [7:0] rand_data();
        logic [7:0] v;
        v = 8'($urandom_range(1, 255));
        return v;
    endfunction

    function automatic logic [7:0] rand_bad_cmd();
        logic [7:0] v;
        v = 8'($urandom_range(0, 255));
        while (is_known(v)) v = v + 8'd5;
        return v;
    endfunction

    // Output sink: random ready, compares against the expected queue.
    always @(negedge clk) begin
        out_ready = (($urandom % 100) < rate);
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected output byte", int'(out_data), -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(out_data == e, cur_req, "output byte", int'(out_data), int'(e));
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_data  = 8'h41;
    endtask

    task automatic drain(input string req);
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(exp_q.size() == 0, req, "bytes left undelivered", exp_q.size(), 0);
    endtask

    task automatic pause_and_measure(input logic [7:0] len, input string req);
        int n;
        send(8'h00);
        send(8'h82);
        send(len);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            #2;
            if (in_ready) break;
            n++;
        end
        check(n == int'(len) * TICK_DIV, req, "pause stall cycles", n, int'(len) * TICK_DIV);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        check(!out_valid, "R1", "out_valid in reset", out_valid, 0);
        check(!line_break, "R1", "line_break in reset", line_break, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        check(!line_break, "R1", "line_break after reset", line_break, 0);
        check(!busy, "R1", "busy after reset", busy, 0);
        check(!cmd_err, "R1", "cmd_err after reset", cmd_err, 0);

        // R2: pass-through with parsing off, zeros included
        cur_req = "R2";
        cmd_en = 1'b0;
        rate = 60;
        for (int i = 0; i < 40; i++) begin
            logic [7:0] b;
            b = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
            exp_q.push_back(b);
            send(b);
        end
        drain("R2");
        check(!busy && !line_break, "R2", "no command effect when disabled", busy, 0);

        // R4: literal zero
        cur_req = "R4";
        cmd_en = 1'b1;
        rate = 100;
        send(8'h00);
        #1;
        check(busy, "R10", "busy after escape", busy, 1);
        exp_q.push_back(8'h00);
        send(8'h00);
        #1;
        check(!busy, "R10", "busy after literal sequence", busy, 0);
        drain("R4");

        // R5/R6: break on, data held off, break off
        cur_req = "R5";
        send(8'h00);
        send(8'h81);
        check(line_break, "R5", "line_break after start", line_break, 1);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h55;
        for (int i = 0; i < 12; i++) begin
            #2;
            check(!in_ready, "R5", "data accepted during break", in_ready, 0);
            check(!out_valid, "R5", "output during break", out_valid, 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_data  = 8'h41;
        cur_req = "R6";
        send(8'h00);
        send(8'h83);
        check(!line_break, "R6", "line_break after stop", line_break, 0);
        exp_q.push_back(8'h55);
        send(8'h55);
        drain("R6");

        // R7: pauses of several lengths, zero included
        cur_req = "R7";
        pause_and_measure(8'd0, "R7");
        pause_and_measure(8'd1, "R7");
        pause_and_measure(8'd5, "R7");
        send(8'h00);
        send(8'h82);
        send(8'd4);
        #1;
        check(busy, "R10", "busy during pause", busy, 1);
        repeat (4 * TICK_DIV + 1) @(negedge clk);
        #2;
        check(!busy, "R10", "busy after pause", busy, 0);

        // R8: unknown command dropped, error sticky
        cur_req = "R8";
        check(!cmd_err, "R8", "cmd_err before unknown", cmd_err, 0);
        send(8'h00);
        send(8'h7e);
        check(cmd_err, "R8", "cmd_err after unknown", cmd_err, 1);
        exp_q.push_back(8'h12);
        send(8'h12);
        drain("R8");
        check(cmd_err, "R8", "cmd_err stays set", cmd_err, 1);

        // R9: output held while transmitter stalls
        rate = 0;
        exp_q.push_back(8'hA5);
        send(8'hA5);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #2;
            check(out_valid && out_data == 8'hA5, "R9", "held output", int'(out_data), 165);
        end
        rate = 100;
        drain("R9");

        // R3: random token mix with parsing on
        cur_req = "R3";
        for (int i = 0; i < 300; i++) begin
            int k;
            rate = 30 + int'($urandom % 71);
            k = int'($urandom % 10);
            if (k < 5) begin
                logic [7:0] b;
                b = rand_data();
                exp_q.push_back(b);
                send(b);
            end else if (k == 5) begin
                exp_q.push_back(8'h00);
                send(8'h00);
                send(8'h00);
            end else if (k == 6) begin
                send(8'h00);
                send(8'h81);
                send(8'h00);
                send(8'h83);
            end else if (k == 7) begin
                send(8'h00);
                send(8'h82);
                send(8'($urandom % 8));
            end else begin
                send(8'h00);
                send(rand_bad_cmd());
            end
        end
        drain("R3");
        check(!line_break && cmd_err, "R3", "final flags", line_break, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule